// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access to a synchronous memory. An address strobe captures an external start address, and each later advance request steps the burst on by one beat. Only the two lowest address bits take part in the stepping. The upper bits stay at the captured value for the whole burst.

The block accepts two address strobes. The controller strobe always captures the address. The processor strobe captures it only while the primary chip select is asserted, and it is ignored otherwise. If neither strobe captures, an asserted advance strobe moves to the next beat. An idle advance strobe holds the current address, which inserts wait states into the burst.

A mode pin picks the beat order while the block runs. When it is high, the order is interleaved: the beat count is XORed into the start bits. When it is low, the order is linear: the beat count is added to the start bits, modulo 4. After the fourth beat the sequence wraps back to its first beat.

All strobes are active low and sampled on the rising clock edge. There is no data stream here, so every pin is a plain level with no handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, `addr_out` becomes all zeros on that edge.
- R2: When `ctrl_strobe_n` is low at a rising edge, `addr_out` equals the `ext_addr` sampled at that edge, whatever the levels of `cs_n` and `adv_n`.
- R3: When `proc_strobe_n` and `cs_n` are both low at a rising edge, `addr_out` equals the sampled `ext_addr`.
- R4: When `proc_strobe_n` is low but `cs_n` is high, the processor strobe has no effect. With `ctrl_strobe_n` and `adv_n` high, `addr_out` keeps its value.
- R5: With `mode` = 1 (interleaved), the low two bits on beat k are start XOR k. A start of 01 gives 01, 00, 11, 10. A start of 10 gives 10, 11, 00, 01.
- R6: With `mode` = 0 (linear), the low two bits on beat k are (start + k) mod 4. A start of 10 gives 10, 11, 00, 01.
- R7: During a burst, `addr_out` bits above bit 1 keep the captured value.
- R8: With no capture and `adv_n` high, `addr_out` is held (a wait state).
- R9: An advance from the fourth beat returns to the first beat of the same sequence.
- R10: A capture in the middle of a burst restarts at beat 0 on the new address, even if `adv_n` is low on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by `cs_n` |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, ungated |
| adv_n | input | 1 | Advance request, active low |
| cs_n | input | 1 | Primary chip select, active low |
| mode | input | 1 | Beat order: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The properties assume that `mode` changes only between bursts. The hold and step checks apply only when `mode` has the same value on two adjacent edges. The stimulus sets `mode` together with a capture and keeps it fixed until the next capture. All inputs are driven just after the falling edge, so they are settled at each rising edge where they are sampled.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_order_e;

  localparam int unsigned DEFAULT_BEAT_W = 2;

endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic cs_n,
  input  logic adv_n,
  output logic load,
  output logic step
);

  logic proc_take;
  logic ctrl_take;

  always_comb begin
    ctrl_take = ~ctrl_strobe_n;
    proc_take = ~proc_strobe_n & ~cs_n;
    load      = ctrl_take | proc_take;
    // a capture always wins over an advance request
    step      = ~load & ~adv_n;
  end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
    end else if (load) begin
      beat <= '0;
    end else if (step) begin
      // natural wrap after the last beat
      beat <= beat + BEAT_ONE;
    end
  end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
    end else if (load) begin
      base <= ext_addr;
    end
  end

endmodule

// File: rtl/burst_addr_compose.sv
module burst_addr_compose
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  seq_order_e        order,
  output logic [ADDR_W-1:0] addr
);

  logic [BEAT_W-1:0] lo_xor;
  logic [BEAT_W-1:0] lo_sum;
  logic [BEAT_W-1:0] lo_sel;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor_bit
      assign lo_xor[gi] = base[gi] ^ beat[gi];
    end
  endgenerate

  assign lo_sum = base[BEAT_W-1:0] + beat;

  always_comb begin
    lo_sel = (order == SEQ_INTERLEAVE) ? lo_xor : lo_sum;
    addr   = {base[ADDR_W-1:BEAT_W], lo_sel};
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = DEFAULT_BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              cs_n,
  input  logic              mode,
  output logic [ADDR_W-1:0] addr_out
);

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;
  seq_order_e        order;

  assign order = seq_order_e'(mode);

  burst_load_ctrl u_load (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .cs_n          (cs_n),
    .adv_n         (adv_n),
    .load          (load),
    .step          (step)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step),
    .beat (beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ext_addr (ext_addr),
    .base     (base)
  );

  burst_addr_compose #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_compose (
    .base  (base),
    .beat  (beat),
    .order (order),
    .addr  (addr_out)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              adv_n,
  input logic              cs_n,
  input logic              mode,
  input logic [ADDR_W-1:0] addr_out
);

  logic no_cap;
  assign no_cap = ctrl_strobe_n & (proc_strobe_n | cs_n);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> addr_out == '0);

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_strobe_n |=> addr_out == $past(ext_addr));

  p_proc_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!proc_strobe_n && !cs_n) |=> addr_out == $past(ext_addr));

  // R4 and R8: with no capture and no advance, the address is held
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (no_cap && adv_n) |=> (mode != $past(mode)) || $stable(addr_out));

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (rst)
    no_cap |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
    (no_cap && !adv_n && !mode) |=> mode ||
      (addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1)));

  p_interleave_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (no_cap && !adv_n && mode) |=> !mode ||
      ($countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) != 0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ext_addr      (ext_addr),
  .proc_strobe_n (proc_strobe_n),
  .ctrl_strobe_n (ctrl_strobe_n),
  .adv_n         (adv_n),
  .cs_n          (cs_n),
  .mode          (mode),
  .addr_out      (addr_out)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          proc_strobe_n = 1'b1;
  logic          ctrl_strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          cs_n = 1'b1;
  logic          mode = 1'b1;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
    .clk           (clk),
    .rst           (rst),
    .ext_addr      (ext_addr),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .cs_n          (cs_n),
    .mode          (mode),
    .addr_out      (addr_out)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      failures++;
      $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] start,
                                              input int k, input logic m);
    logic [1:0] lo;
    lo = m ? (start[1:0] ^ 2'(k)) : 2'(start[1:0] + 2'(k));
    return {start[AW-1:2], lo};
  endfunction

  // one clock: inputs already set after a falling edge, advance to the next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic ctrl_load(input logic [AW-1:0] a, input logic m);
    ext_addr = a; mode = m; ctrl_strobe_n = 1'b0; proc_strobe_n = 1'b1; adv_n = 1'b1;
    tick();
    idle();
  endtask

  task automatic advance();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b0;
    tick();
    idle();
  endtask

  task automatic t_reset();
    check("R1", '0);
    ctrl_load(18'h2ABCD, 1'b1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1", '0);
  endtask

  task automatic t_ctrl_load();
    cs_n = 1'b1;
    ctrl_load(18'h01235, 1'b1);
    check("R2", 18'h01235);
    cs_n = 1'b0;
    ext_addr = 18'h3FFFE; ctrl_strobe_n = 1'b0; adv_n = 1'b0;
    tick(); idle();
    check("R2", 18'h3FFFE);
  endtask

  task automatic t_proc_load();
    cs_n = 1'b0;
    ext_addr = 18'h00ABC; proc_strobe_n = 1'b0;
    tick(); idle();
    check("R3", 18'h00ABC);
  endtask

  task automatic t_proc_ignored();
    cs_n = 1'b1;
    ext_addr = 18'h17777; proc_strobe_n = 1'b0; adv_n = 1'b1;
    tick(); idle();
    check("R4", 18'h00ABC);
    tick();
    check("R4", 18'h00ABC);
  endtask

  task automatic t_order(input logic [AW-1:0] start, input logic m, input string req);
    ctrl_load(start, m);
    check(req, beat_addr(start, 0, m));
    for (int k = 1; k < 4; k++) begin
      advance();
      check(req, beat_addr(start, k, m));
      if (addr_out[AW-1:2] !== start[AW-1:2]) begin
        checks++; failures++;
        $display("FAIL R7 upper=%h expected=%h", addr_out[AW-1:2], start[AW-1:2]);
      end else checks++;
    end
    advance();
    check("R9", start);
  endtask

  task automatic t_wait();
    ctrl_load(18'h0C001, 1'b0);
    advance();
    check("R6", 18'h0C002);
    tick();
    check("R8", 18'h0C002);
    tick();
    check("R8", 18'h0C002);
    advance();
    check("R8", 18'h0C003);
  endtask

  task automatic t_midload();
    ctrl_load(18'h05551, 1'b1);
    advance();
    advance();
    check("R5", 18'h05553);
    ext_addr = 18'h2222E; ctrl_strobe_n = 1'b0; adv_n = 1'b0;
    tick(); idle();
    check("R10", 18'h2222E);
    advance();
    check("R10", 18'h2222F);
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_ctrl_load();
    t_proc_load();
    t_proc_ignored();
    t_order(18'h05551, 1'b1, "R5");
    t_order(18'h04442, 1'b1, "R5");
    t_order(18'h04442, 1'b0, "R6");
    t_order(18'h3FFFF, 1'b0, "R6");
    t_wait();
    t_midload();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule